// File: doc/BRIEF.md
# Transactional Line Conflict Tracker

This block sits beside a small L1 data cache tag array and follows one core's hardware transaction. While a transaction is open it keeps two bit vectors, one bit per cache line: a read mark for every line the core loads and a write mark for every line it stores. Each incoming coherence snoop from another agent, and each eviction notice from the cache, is checked against these marks. When a conflict is found, the local transaction is killed. The agent that made the request is never stalled, and it makes no difference whether that agent is itself inside a transaction.

When a transaction is killed, the block clears both vectors and pulses a mask of the lines that carry speculative data, so the cache can invalidate them. It also reports a cause code and the fallback address that was captured when the transaction opened. When a transaction ends cleanly, the block pulses a commit strobe and clears the marks. The lines that were written stay as ordinary modified lines. While a snoop hits a speculatively written line, a combinational flag tells the cache not to supply that line's data. As a result, other agents observe either all of the transaction's writes or none of them.

Top module: `txc_tracker`

## Requirements
- R1: After reset, `tx_active_o`, `abort_o`, `commit_o`, `snp_nodata_o`, `line_inval_o` and `abort_cause_o` are all zero.
- R2: A load hit inside an open transaction marks its line as read, and a store hit marks its line as written. The marks are observable through the snoop response to that line.
- R3: A snoop read (`snp_wr_i`=0) that hits a written line of the open transaction makes `abort_o` high in the next cycle, with `abort_cause_o`=1 (conflict). A snoop read that hits a line that is only read-marked has no effect.
- R4: A snoop write (`snp_wr_i`=1) that hits a read-marked or write-marked line causes an abort in the next cycle, with cause 1.
- R5: An eviction notice for a line that carries either mark causes an abort in the next cycle, with cause 2 (capacity). Evicting an unmarked line has no effect.
- R6: `tx_abort_i` during an open transaction causes an abort in the next cycle, with cause 3 (explicit). If several causes occur in the same cycle, the priority is conflict, then capacity, then explicit.
- R7: Whenever `abort_o` is high, `restart_pc_o` equals the `tx_begin_pc_i` value sampled when the transaction opened.
- R8: In the abort cycle, `line_inval_o` equals the set of write-marked lines. At any other time it is zero. After any abort or commit, all marks are clear.
- R9: `tx_end_i` during an open transaction with no conflict in that cycle gives a one-cycle `commit_o` in the next cycle. `line_inval_o` stays zero and the transaction closes.
- R10: If `tx_end_i` arrives in the same cycle as a conflicting snoop, the result is an abort and not a commit.
- R11: While no transaction is open, snoops, evictions, accesses, `tx_end_i` and `tx_abort_i` never raise `abort_o` or `commit_o`.
- R12: `snp_nodata_o` is high in the same cycle as a valid snoop that hits a write-marked line of the open transaction, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_begin_i | input | 1 | Open a transaction (ignored if one is already open) |
| tx_begin_pc_i | input | PC_W | Fallback address captured on open |
| tx_end_i | input | 1 | Request commit |
| tx_abort_i | input | 1 | Explicit abort request |
| ld_hit_i | input | 1 | Local load hit |
| ld_idx_i | input | IDX_W | Line index of the load |
| st_hit_i | input | 1 | Local store hit |
| st_idx_i | input | IDX_W | Line index of the store |
| snp_vld_i | input | 1 | Snoop from another agent (at most one per cycle) |
| snp_wr_i | input | 1 | Snoop kind: 1 = write/ownership, 0 = read |
| snp_idx_i | input | IDX_W | Snooped line index |
| evict_vld_i | input | 1 | Eviction notice |
| evict_idx_i | input | IDX_W | Evicted line index |
| tx_active_o | output | 1 | Transaction open |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_cause_o | output | 2 | 0 none, 1 conflict, 2 capacity, 3 explicit |
| restart_pc_o | output | PC_W | Fallback address of the current or last transaction |
| commit_o | output | 1 | One-cycle commit pulse |
| line_inval_o | output | LINES | Lines to invalidate, valid with abort |
| snp_nodata_o | output | 1 | Do not supply data for this snoop |

## Verification
The hardest case to reach is a commit request that arrives in the same cycle as a conflicting snoop. In that cycle the two outcomes compete, and only one of them may appear on the next edge. The stimulus table reaches it by opening a transaction, loading a line, and then driving `tx_end_i` together with a snoop write to that line in a single vector. It also covers an eviction racing an open transaction and a snoop read landing on a line that is only read-marked. Directed steps afterwards check the invalidation mask for a transaction with two written lines and the same-cycle suppression flag.

// File: rtl/txc_pkg.sv
package txc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_CONFLICT = 2'd1,
    CAUSE_CAPACITY = 2'd2,
    CAUSE_EXPLICIT = 2'd3
  } abort_cause_e;
endpackage

// File: rtl/txc_set_bank.sv
module txc_set_bank #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             clear_i,
  output logic [LINES-1:0] bits_o
);
  logic [LINES-1:0] bits_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic bit_d;
    always_comb begin
      bit_d = bits_q[g];
      if (clear_i)                                   bit_d = 1'b0;
      else if (mark_i && (idx_i == IDX_W'(g)))       bit_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q[g] <= 1'b0;
      else        bits_q[g] <= bit_d;
    end
  end

  assign bits_o = bits_q;

  // R8: a clear leaves no mark behind
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (bits_o == '0));
endmodule

// File: rtl/txc_conflict_detect.sv
module txc_conflict_detect #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             active_i,
  input  logic [LINES-1:0] rset_i,
  input  logic [LINES-1:0] wset_i,
  input  logic             snp_vld_i,
  input  logic             snp_wr_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic             evict_vld_i,
  input  logic [IDX_W-1:0] evict_idx_i,
  output logic             conflict_o,
  output logic             capacity_o,
  output logic             nodata_o
);
  logic snp_rhit, snp_whit, ev_hit;

  always_comb begin
    snp_rhit   = rset_i[snp_idx_i];
    snp_whit   = wset_i[snp_idx_i];
    ev_hit     = rset_i[evict_idx_i] | wset_i[evict_idx_i];
    conflict_o = active_i & snp_vld_i & (snp_whit | (snp_wr_i & snp_rhit));
    capacity_o = active_i & evict_vld_i & ev_hit;
    nodata_o   = active_i & snp_vld_i & snp_whit;
  end
endmodule

// File: rtl/txc_tracker.sv
module txc_tracker #(
  parameter int LINES = 16,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_begin_i,
  input  logic [PC_W-1:0]  tx_begin_pc_i,
  input  logic             tx_end_i,
  input  logic             tx_abort_i,
  input  logic             ld_hit_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic             st_hit_i,
  input  logic [IDX_W-1:0] st_idx_i,
  input  logic             snp_vld_i,
  input  logic             snp_wr_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic             evict_vld_i,
  input  logic [IDX_W-1:0] evict_idx_i,
  output logic             tx_active_o,
  output logic             abort_o,
  output logic [1:0]       abort_cause_o,
  output logic [PC_W-1:0]  restart_pc_o,
  output logic             commit_o,
  output logic [LINES-1:0] line_inval_o,
  output logic             snp_nodata_o
);
  import txc_pkg::*;

  logic             active_q, active_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic             abort_q, abort_d;
  abort_cause_e     cause_q, cause_d;
  logic             commit_q, commit_d;
  logic [LINES-1:0] inval_q, inval_d;

  logic [LINES-1:0] rset, wset;
  logic             conflict, capacity, kill, commit_now, clear_sets;
  logic             rd_mark, wr_mark, open_now;

  txc_conflict_detect #(.LINES(LINES)) u_detect (
    .active_i    (active_q),
    .rset_i      (rset),
    .wset_i      (wset),
    .snp_vld_i   (snp_vld_i),
    .snp_wr_i    (snp_wr_i),
    .snp_idx_i   (snp_idx_i),
    .evict_vld_i (evict_vld_i),
    .evict_idx_i (evict_idx_i),
    .conflict_o  (conflict),
    .capacity_o  (capacity),
    .nodata_o    (snp_nodata_o)
  );

  txc_set_bank #(.LINES(LINES)) u_rset (
    .clk (clk), .rst_n (rst_n), .mark_i (rd_mark), .idx_i (ld_idx_i),
    .clear_i (clear_sets), .bits_o (rset)
  );

  txc_set_bank #(.LINES(LINES)) u_wset (
    .clk (clk), .rst_n (rst_n), .mark_i (wr_mark), .idx_i (st_idx_i),
    .clear_i (clear_sets), .bits_o (wset)
  );

  // Next-state logic
  always_comb begin
    kill       = active_q & (conflict | capacity | tx_abort_i);
    commit_now = active_q & tx_end_i & ~kill;
    open_now   = ~active_q & tx_begin_i;
    rd_mark    = active_q & ld_hit_i & ~kill;
    wr_mark    = active_q & st_hit_i & ~kill;
    clear_sets = kill | commit_now | open_now;

    active_d = active_q;
    if (kill || commit_now) active_d = 1'b0;
    else if (open_now)      active_d = 1'b1;

    pc_d = open_now ? tx_begin_pc_i : pc_q;

    abort_d  = kill;
    commit_d = commit_now;
    inval_d  = kill ? wset : '0;
    if (!kill)          cause_d = CAUSE_NONE;
    else if (conflict)  cause_d = CAUSE_CONFLICT;
    else if (capacity)  cause_d = CAUSE_CAPACITY;
    else                cause_d = CAUSE_EXPLICIT;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pc_q     <= '0;
      abort_q  <= 1'b0;
      cause_q  <= CAUSE_NONE;
      commit_q <= 1'b0;
      inval_q  <= '0;
    end else begin
      active_q <= active_d;
      if (open_now) pc_q <= pc_d;
      abort_q  <= abort_d;
      cause_q  <= cause_d;
      commit_q <= commit_d;
      inval_q  <= inval_d;
    end
  end

  assign tx_active_o   = active_q;
  assign abort_o       = abort_q;
  assign abort_cause_o = cause_q;
  assign restart_pc_o  = pc_q;
  assign commit_o      = commit_q;
  assign line_inval_o  = inval_q;

  // R3: snoop read onto a written line aborts one cycle later as a conflict
  p_rd_snoop_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active_o && snp_vld_i && !snp_wr_i && wset[snp_idx_i])
      |=> (abort_o && abort_cause_o == 2'd1));

  // R10: abort and commit never pulse together
  p_abort_commit_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_o && commit_o));

  // R11: nothing is raised one cycle after an idle cycle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active_o |=> (!abort_o && !commit_o));

  // R8: the invalidation mask only appears alongside an abort
  p_inval_with_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_inval_o != '0) |-> abort_o);

  // R7: the fallback address holds while a transaction stays open
  p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active_o && $past(tx_active_o)) |-> $stable(restart_pc_o));

  // R9: a completed transaction is closed when the pulse appears
  p_pulse_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_o || commit_o) |-> !tx_active_o);
endmodule

// File: tb/test_txc_tracker.sv
module test_txc_tracker;
  localparam int LINES = 16;
  localparam int PC_W  = 32;
  localparam int IDX_W = $clog2(LINES);
  localparam logic [PC_W-1:0] PC0 = 32'h0000_4A40;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_begin_i, tx_end_i, tx_abort_i;
  logic [PC_W-1:0] tx_begin_pc_i;
  logic ld_hit_i, st_hit_i, snp_vld_i, snp_wr_i, evict_vld_i;
  logic [IDX_W-1:0] ld_idx_i, st_idx_i, snp_idx_i, evict_idx_i;
  logic tx_active_o, abort_o, commit_o, snp_nodata_o;
  logic [1:0] abort_cause_o;
  logic [PC_W-1:0] restart_pc_o;
  logic [LINES-1:0] line_inval_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  txc_tracker #(.LINES(LINES), .PC_W(PC_W)) i_txc_tracker (.*);

  typedef struct packed {
    logic b, e, x, ld; logic [3:0] li;
    logic st; logic [3:0] si;
    logic sv, sw; logic [3:0] sx;
    logic ev; logic [3:0] ex;
    logic eab, ecm, eact; logic [1:0] ecs;
  } vec_t;

  localparam int NV = 22;
  // fields: b e x ld li st si sv sw sx ev ex | abort commit active cause
  localparam vec_t VEC [NV] = '{
    '{1,0,0,0,4'd0,0,4'd0,0,0,4'd0,0,4'd0, 0,0,1,2'd0}, // open
    '{0,0,0,1,4'd3,0,4'd0,0,0,4'd0,0,4'd0, 0,0,1,2'd0}, // R2 load 3
    '{0,0,0,0,4'd0,1,4'd5,0,0,4'd0,0,4'd0, 0,0,1,2'd0}, // R2 store 5
    '{0,0,0,0,4'd0,0,4'd0,1,0,4'd3,0,4'd0, 0,0,1,2'd0}, // R3 read snoop on read-only line
    '{0,0,0,0,4'd0,0,4'd0,1,0,4'd5,0,4'd0, 1,0,0,2'd1}, // R3 read snoop on written line
    '{0,0,0,0,4'd0,0,4'd0,1,1,4'd5,0,4'd0, 0,0,0,2'd0}, // R11 idle snoop
    '{1,0,0,0,4'd0,0,4'd0,0,0,4'd0,0,4'd0, 0,0,1,2'd0},
    '{0,0,0,1,4'd7,0,4'd0,0,0,4'd0,0,4'd0, 0,0,1,2'd0},
    '{0,0,0,0,4'd0,0,4'd0,1,1,4'd7,0,4'd0, 1,0,0,2'd1}, // R4 write snoop on read line
    '{1,0,0,0,4'd0,0,4'd0,0,0,4'd0,0,4'd0, 0,0,1,2'd0},
    '{0,0,0,0,4'd0,1,4'd2,0,0,4'd0,0,4'd0, 0,0,1,2'd0},
    '{0,0,0,0,4'd0,0,4'd0,0,0,4'd0,1,4'd2, 1,0,0,2'd2}, // R5 evict marked line
    '{1,0,0,0,4'd0,0,4'd0,0,0,4'd0,0,4'd0, 0,0,1,2'd0},
    '{0,0,0,1,4'd1,0,4'd0,0,0,4'd0,0,4'd0, 0,0,1,2'd0},
    '{0,0,0,0,4'd0,0,4'd0,0,0,4'd0,1,4'd9, 0,0,1,2'd0}, // R5 evict unmarked line
    '{0,1,0,0,4'd0,0,4'd0,0,0,4'd0,0,4'd0, 0,1,0,2'd0}, // R9 commit
    '{1,0,0,0,4'd0,0,4'd0,0,0,4'd0,0,4'd0, 0,0,1,2'd0},
    '{0,0,0,1,4'd4,0,4'd0,0,0,4'd0,0,4'd0, 0,0,1,2'd0},
    '{0,1,0,0,4'd0,0,4'd0,1,1,4'd4,0,4'd0, 1,0,0,2'd1}, // R10 commit vs conflict
    '{1,0,0,0,4'd0,0,4'd0,0,0,4'd0,0,4'd0, 0,0,1,2'd0},
    '{0,0,1,0,4'd0,0,4'd0,0,0,4'd0,1,4'd0, 1,0,0,2'd3}, // R6 explicit
    '{0,1,1,0,4'd0,0,4'd0,0,0,4'd0,1,4'd0, 0,0,0,2'd0}  // R11 idle end/abort/evict
  };

  task automatic idle_inputs();
    tx_begin_i = 0; tx_end_i = 0; tx_abort_i = 0; tx_begin_pc_i = PC0;
    ld_hit_i = 0; ld_idx_i = '0; st_hit_i = 0; st_idx_i = '0;
    snp_vld_i = 0; snp_wr_i = 0; snp_idx_i = '0; evict_vld_i = 0; evict_idx_i = '0;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, step one clock, sample at the following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {tx_active_o, abort_o, commit_o, snp_nodata_o, abort_cause_o}, 0);
    check("R1", 64'(line_inval_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      idle_inputs();
      tx_begin_i = VEC[i].b; tx_end_i = VEC[i].e; tx_abort_i = VEC[i].x;
      ld_hit_i = VEC[i].ld; ld_idx_i = VEC[i].li;
      st_hit_i = VEC[i].st; st_idx_i = VEC[i].si;
      snp_vld_i = VEC[i].sv; snp_wr_i = VEC[i].sw; snp_idx_i = VEC[i].sx;
      evict_vld_i = VEC[i].ev; evict_idx_i = VEC[i].ex;
      step();
      check($sformatf("R2-R11 vector %0d", i),
            {abort_o, commit_o, tx_active_o, abort_cause_o},
            {VEC[i].eab, VEC[i].ecm, VEC[i].eact, VEC[i].ecs});
    end

    // R8 / R7 / R12: two written lines, read-only line, then conflict
    idle_inputs(); tx_begin_i = 1; tx_begin_pc_i = 32'h0000_ABC0; step();
    idle_inputs(); tx_begin_pc_i = 32'h1111_1111; st_hit_i = 1; st_idx_i = 4'd2; step();
    idle_inputs(); st_hit_i = 1; st_idx_i = 4'd6; ld_hit_i = 1; ld_idx_i = 4'd9; step();
    idle_inputs(); snp_vld_i = 1; snp_idx_i = 4'd9; #1;
    check("R12 read-only line", 64'(snp_nodata_o), 0);
    check("R8 no mask outside abort", 64'(line_inval_o), 0);
    snp_idx_i = 4'd6; #1;
    check("R12 written line", 64'(snp_nodata_o), 1);
    step();
    idle_inputs();
    check("R3 abort", {abort_o, abort_cause_o}, {1'b1, 2'd1});
    check("R8 mask", 64'(line_inval_o), 64'h0044);
    check("R7 restart", 64'(restart_pc_o), 64'h0000_ABC0);
    #1;
    check("R12 idle", 64'(snp_nodata_o), 0);
    step();
    check("R8 mask clears", 64'(line_inval_o), 0);

    // R9 / R8: commit leaves no mask and clears marks for the next transaction
    idle_inputs(); tx_begin_i = 1; step();
    idle_inputs(); st_hit_i = 1; st_idx_i = 4'd11; step();
    idle_inputs(); tx_end_i = 1; #1;
    check("R9 mask", 64'(line_inval_o), 0);
    step();
    check("R9 commit", {commit_o, abort_o, line_inval_o}, {1'b1, 1'b0, 16'h0});
    idle_inputs(); tx_begin_i = 1; step();
    idle_inputs(); snp_vld_i = 1; snp_wr_i = 1; snp_idx_i = 4'd11; step();
    check("R8 marks cleared after commit", {abort_o, tx_active_o}, 2'b01);
    // R6 priority: capacity and explicit together -> capacity
    idle_inputs(); ld_hit_i = 1; ld_idx_i = 4'd12; step();
    idle_inputs(); tx_abort_i = 1; evict_vld_i = 1; evict_idx_i = 4'd12; step();
    check("R6 priority", {abort_o, abort_cause_o}, {1'b1, 2'd2});
    idle_inputs(); step();
    finish_run();
  end
endmodule